// File: doc/BRIEF.md
# Lock-step pair checker with split data and parity drive

This block wraps two identical copies of a small registered datapath. Both copies take the same inputs and step together on every clock. The two copies share one 16-bit data bus and a 2-bit parity bus. Copy 0 is the data master: only its data drivers are enabled. Copy 1 is the parity master: only its parity drivers are enabled. Each copy compares the word and parity it produced with the values actually on the shared bus. Each copy also checks the parity that arrives with its input word. Any disagreement halts the pair at once, and the halt holds until reset.

The modelled function is a byte swap of the input word followed by an XOR with the parameter `KEY`. The result is registered in the cycle the input is marked valid. Because no single copy drives a complete word with its parity, a wrong value from either copy appears on the bus, and the other copy's checker sees it. Fault inputs flip bits in each copy's generated data or parity, or force each copy's comparator stuck. These inputs exist so that detection can be shown from the ports.

Top module: `xcheck_pair`

## Requirements
- R1: During reset and in the first cycle after it, `fail` is 2'b00, `halt` is 0 and `bus_oe` is 0.
- R2: If `in_valid` is 1 with correct parity and the pair is not halted, then on the next clock edge `bus_oe` becomes 1 and `bus_data` becomes `{in_data[7:0], in_data[15:8]} ^ KEY` (default KEY 16'hA5C3). For example, input 16'h1234 gives 16'h91D1.
- R3: `bus_par[b]` is the XOR of `bus_data[8b+7:8b]`, so bit 0 covers the low byte. Each byte together with its parity bit holds an even number of ones. The same rule applies to `in_par` against `in_data`.
- R4: After a clock edge at which `in_valid` was 0, `bus_oe` is 0 and both buses read zero. No comparison is made in such a cycle, so a comparator stuck at mismatch leaves `fail` at 0.
- R5: A valid input word whose `in_par` breaks the R3 rule sets both `fail` bits at that clock edge.
- R6: A single-bit data fault in either copy (`flt_data[i]`, which flips bit 0 of that copy's word) sets both `fail` bits one edge after the faulty word is on the bus.
- R7: A parity fault (`flt_par[i]`, which flips parity bit 0 of copy i) sets only `fail[0]`, for either copy.
- R8: A comparator in copy i stuck at mismatch (`chk_hi[i]`) sets only `fail[i]`, one edge after a driven cycle.
- R9: With copy i's comparator stuck at match (`chk_lo[i]`), a data fault in copy i is still caught by the other copy: `fail` has only the other bit set.
- R10: `fail` bits stay set until reset. `halt` is the OR of the `fail` bits, and while `halt` is 1, `bus_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word present this cycle |
| in_data | input | 16 | Input word, shared by both copies |
| in_par | input | 2 | Even parity per byte of in_data |
| flt_data | input | 2 | Per-copy fault: flip bit 0 of generated word |
| flt_par | input | 2 | Per-copy fault: flip parity bit 0 |
| chk_hi | input | 2 | Per-copy fault: comparator stuck at mismatch |
| chk_lo | input | 2 | Per-copy fault: comparator stuck at match |
| bus_data | output | 16 | Shared data bus, driven by copy 0 |
| bus_par | output | 2 | Shared parity bus, driven by copy 1 |
| bus_oe | output | 1 | Buses carry a driven word |
| fail | output | 2 | Sticky per-copy error flags |
| halt | output | 1 | Fail-fast stop of the pair |

## Verification
The hardest case to reach is a latent checker fault combined with a second fault. A comparator stuck at match gives no sign of itself at the ports. The stimulus therefore holds `chk_lo` on one copy and injects a data fault into that same copy during a driven cycle. Only the other copy's flag may rise. A second hard case is a stuck-mismatch comparator during idle cycles, which must stay silent until a word is actually driven. This is reached by holding `chk_hi` across an idle stretch before any valid input.

// File: rtl/xcheck_pkg.sv
package xcheck_pkg;
    localparam int WORD_W  = 16;
    localparam int BYTE_W  = 8;
    localparam int PAR_W   = WORD_W / BYTE_W;
    localparam int COPIES  = 2;
    localparam int DATA_MASTER = 0;
    localparam int PAR_MASTER  = 1;

    typedef struct packed {
        logic [WORD_W-1:0] data;
        logic [PAR_W-1:0]  par;
    } bus_word_t;

    function automatic logic [PAR_W-1:0] even_par(input logic [WORD_W-1:0] d);
        logic [PAR_W-1:0] p;
        for (int b = 0; b < PAR_W; b++) p[b] = ^d[b*BYTE_W +: BYTE_W];
        return p;
    endfunction

    function automatic logic [WORD_W-1:0] swap_bytes(input logic [WORD_W-1:0] d);
        logic [WORD_W-1:0] r;
        for (int b = 0; b < PAR_W; b++)
            r[b*BYTE_W +: BYTE_W] = d[(PAR_W-1-b)*BYTE_W +: BYTE_W];
        return r;
    endfunction
endpackage

// File: rtl/xcheck_core.sv
module xcheck_core
    import xcheck_pkg::*;
#(
    parameter logic [WORD_W-1:0] KEY = 16'hA5C3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_data,
    input  logic              flt_data,
    input  logic              flt_par,
    output bus_word_t         gen,
    output logic              drv
);
    logic [WORD_W-1:0] word_q;
    logic [WORD_W-1:0] word_f;

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
            drv    <= 1'b0;
        end else begin
            drv <= in_valid;
            if (in_valid) word_q <= swap_bytes(in_data) ^ KEY;
        end
    end

    always_comb begin
        word_f   = word_q ^ {{(WORD_W-1){1'b0}}, flt_data};
        gen.data = word_f;
        gen.par  = even_par(word_f) ^ {{(PAR_W-1){1'b0}}, flt_par};
    end
endmodule

// File: rtl/xcheck_guard.sv
module xcheck_guard
    import xcheck_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  bus_word_t         own,
    input  bus_word_t         seen,
    input  logic              live,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_data,
    input  logic [PAR_W-1:0]  in_par,
    input  logic              stuck_hi,
    input  logic              stuck_lo,
    output logic              fail
);
    logic cmp_raw, cmp_out, in_bad;

    always_comb begin
        cmp_raw = (own.data != seen.data) || (own.par != seen.par);
        cmp_out = stuck_hi || (!stuck_lo && cmp_raw);
        in_bad  = in_valid && (in_par != even_par(in_data));
    end

    always_ff @(posedge clk) begin
        if (rst)                          fail <= 1'b0;
        else if ((live && cmp_out) || in_bad) fail <= 1'b1;
    end
endmodule

// File: rtl/xcheck_pair.sv
module xcheck_pair
    import xcheck_pkg::*;
#(
    parameter logic [WORD_W-1:0] KEY = 16'hA5C3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_data,
    input  logic [PAR_W-1:0]  in_par,
    input  logic [COPIES-1:0] flt_data,
    input  logic [COPIES-1:0] flt_par,
    input  logic [COPIES-1:0] chk_hi,
    input  logic [COPIES-1:0] chk_lo,
    output logic [WORD_W-1:0] bus_data,
    output logic [PAR_W-1:0]  bus_par,
    output logic              bus_oe,
    output logic [COPIES-1:0] fail,
    output logic              halt
);
    bus_word_t         gen [COPIES];
    logic [COPIES-1:0] drv;
    bus_word_t         shared;
    logic              data_en, par_en;

    assign halt    = |fail;
    assign data_en = drv[DATA_MASTER] && !halt;
    assign par_en  = drv[PAR_MASTER]  && !halt;

    always_comb begin
        shared.data = data_en ? gen[DATA_MASTER].data : '0;
        shared.par  = par_en  ? gen[PAR_MASTER].par   : '0;
    end

    assign bus_data = shared.data;
    assign bus_par  = shared.par;
    assign bus_oe   = data_en;

    for (genvar i = 0; i < COPIES; i++) begin : g_copy
        xcheck_core #(.KEY(KEY)) u_core (
            .clk      (clk),
            .rst      (rst),
            .in_valid (in_valid),
            .in_data  (in_data),
            .flt_data (flt_data[i]),
            .flt_par  (flt_par[i]),
            .gen      (gen[i]),
            .drv      (drv[i])
        );
        xcheck_guard u_guard (
            .clk      (clk),
            .rst      (rst),
            .own      (gen[i]),
            .seen     (shared),
            .live     (data_en),
            .in_valid (in_valid),
            .in_data  (in_data),
            .in_par   (in_par),
            .stuck_hi (chk_hi[i]),
            .stuck_lo (chk_lo[i]),
            .fail     (fail[i])
        );
    end
endmodule

// File: rtl/xcheck_pair_sva.sv
module xcheck_pair_sva
    import xcheck_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [WORD_W-1:0] in_data,
    input logic [PAR_W-1:0]  in_par,
    input logic [COPIES-1:0] flt_data,
    input logic [COPIES-1:0] flt_par,
    input logic [COPIES-1:0] chk_hi,
    input logic [COPIES-1:0] chk_lo,
    input logic [WORD_W-1:0] bus_data,
    input logic [PAR_W-1:0]  bus_par,
    input logic              bus_oe,
    input logic [COPIES-1:0] fail,
    input logic              halt
);
    logic no_flt;
    assign no_flt = (flt_data == '0) && (flt_par == '0) && (chk_hi == '0) && (chk_lo == '0);

    a_r10_fail0_sticky: assert property (@(posedge clk) disable iff (rst)
        fail[0] |=> fail[0]);
    a_r10_fail1_sticky: assert property (@(posedge clk) disable iff (rst)
        fail[1] |=> fail[1]);
    a_r10_halt_blocks: assert property (@(posedge clk) disable iff (rst)
        halt |-> !bus_oe);
    a_r4_idle_zero: assert property (@(posedge clk) disable iff (rst)
        !bus_oe |-> (bus_data == '0 && bus_par == '0));
    a_r5_inpar_both: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_par != even_par(in_data)) |=> (fail == 2'b11));
    a_r2_drive_next: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !halt && no_flt && in_par == even_par(in_data)) |=> bus_oe);
    a_r3_bus_parity: assert property (@(posedge clk) disable iff (rst)
        (bus_oe && no_flt) |-> (bus_par == even_par(bus_data)));
endmodule

bind xcheck_pair xcheck_pair_sva u_sva (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data), .in_par(in_par),
    .flt_data(flt_data), .flt_par(flt_par), .chk_hi(chk_hi), .chk_lo(chk_lo),
    .bus_data(bus_data), .bus_par(bus_par), .bus_oe(bus_oe), .fail(fail), .halt(halt)
);

// File: tb/xcheck_pair_test.sv
module xcheck_pair_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [15:0] in_data = '0;
    logic [1:0]  in_par = '0;
    logic [1:0]  flt_data = '0, flt_par = '0, chk_hi = '0, chk_lo = '0;
    logic [15:0] bus_data;
    logic [1:0]  bus_par, fail;
    logic        bus_oe, halt;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    localparam logic [15:0] KEY = 16'hA5C3;

    always #5 clk = ~clk;

    xcheck_pair uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data), .in_par(in_par),
        .flt_data(flt_data), .flt_par(flt_par), .chk_hi(chk_hi), .chk_lo(chk_lo),
        .bus_data(bus_data), .bus_par(bus_par), .bus_oe(bus_oe), .fail(fail), .halt(halt)
    );

    function automatic logic [1:0] bpar(input logic [15:0] d);
        return {^d[15:8], ^d[7:0]};
    endfunction

    // behavioural reference: stored word, drive flag, sticky flags
    logic [15:0] m_word = '0;
    logic        m_drv = 0;
    logic [1:0]  m_fail = '0;

    function automatic logic [15:0] copy_word(input int i);
        return m_word ^ {15'd0, flt_data[i]};
    endfunction
    function automatic logic [1:0] copy_par(input int i);
        return bpar(copy_word(i)) ^ {1'b0, flt_par[i]};
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_word <= '0; m_drv <= 0; m_fail <= '0;
        end else begin
            logic       live;
            logic [1:0] nf;
            live = m_drv && (m_fail == 2'b00);
            nf = m_fail;
            for (int i = 0; i < 2; i++) begin
                logic raw;
                raw = (copy_word(i) != copy_word(0)) || (copy_par(i) != copy_par(1));
                if (live && (chk_hi[i] || (!chk_lo[i] && raw))) nf[i] = 1'b1;
            end
            if (in_valid && in_par != bpar(in_data)) nf = 2'b11;
            m_fail <= nf;
            m_drv  <= in_valid;
            if (in_valid) m_word <= {in_data[7:0], in_data[15:8]} ^ KEY;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // one clock; compare every output against the reference at the falling edge
    task automatic step(input string tag);
        logic e_oe;
        @(negedge clk);
        e_oe = m_drv && (m_fail == 2'b00);
        chk(tag, {31'd0, bus_oe}, {31'd0, e_oe}, "bus_oe");
        chk(tag, {16'd0, bus_data}, {16'd0, e_oe ? copy_word(0) : 16'd0}, "bus_data");
        chk(tag, {30'd0, bus_par}, {30'd0, e_oe ? copy_par(1) : 2'd0}, "bus_par");
        chk(tag, {30'd0, fail}, {30'd0, m_fail}, "fail");
        chk(tag, {31'd0, halt}, {31'd0, |m_fail}, "halt");
    endtask

    task automatic do_reset();
        rst = 1'b1; in_valid = 0;
        flt_data = '0; flt_par = '0; chk_hi = '0; chk_lo = '0;
        step("R1"); step("R1");
        rst = 1'b0;
    endtask

    task automatic put(input logic [15:0] d, input logic good);
        in_valid = 1'b1; in_data = d;
        in_par = bpar(d) ^ {1'b0, !good};
    endtask

    // word with one fault active for two edges, then expected flag pattern
    task automatic fault_case(input string tag, input logic [1:0] fd, input logic [1:0] fp,
                              input logic [1:0] hi, input logic [1:0] lo, input logic [1:0] exp);
        do_reset();
        flt_data = fd; flt_par = fp; chk_hi = hi; chk_lo = lo;
        put(16'h0F0F, 1'b1);
        step(tag);
        in_valid = 0;
        step(tag);
        chk(tag, {30'd0, fail}, {30'd0, exp}, "fail pattern");
        flt_data = '0; flt_par = '0; chk_hi = '0; chk_lo = '0;
        step(tag);
    endtask

    initial begin
        do_reset();
        chk("R1", {30'd0, fail}, 32'd0, "fail after reset");
        chk("R1", {31'd0, bus_oe}, 32'd0, "oe after reset");
        step("R1");
        chk("R1", {31'd0, halt}, 32'd0, "halt after reset");

        // R2/R3 main function, directed value
        put(16'h1234, 1'b1);
        step("R2");
        chk("R2", {16'd0, bus_data}, 32'h91D1, "swapped word");
        chk("R3", {30'd0, bus_par}, 32'd2, "byte parity");
        in_valid = 0;
        step("R4");
        chk("R4", {31'd0, bus_oe}, 32'd0, "idle oe");

        // R2/R3 streams with gaps
        for (int k = 0; k < 24; k++) begin
            if (k % 3 == 2) in_valid = 0;
            else put(16'h9E37 * (k + 1) + 16'h0101 * k, 1'b1);
            step("R2");
        end
        in_valid = 0;
        step("R3");

        // R4: stuck comparator silent while idle
        chk_hi = 2'b11;
        for (int k = 0; k < 4; k++) step("R4");
        chk("R4", {30'd0, fail}, 32'd0, "no compare when idle");
        chk_hi = '0;

        // R5: bad incoming parity
        do_reset();
        put(16'hBEEF, 1'b0);
        step("R5");
        chk("R5", {30'd0, fail}, 32'd3, "input parity error");
        in_valid = 0;
        step("R5");

        fault_case("R6", 2'b01, 2'b00, 2'b00, 2'b00, 2'b11);
        fault_case("R6", 2'b10, 2'b00, 2'b00, 2'b00, 2'b11);
        fault_case("R7", 2'b00, 2'b01, 2'b00, 2'b00, 2'b01);
        fault_case("R7", 2'b00, 2'b10, 2'b00, 2'b00, 2'b01);
        fault_case("R8", 2'b00, 2'b00, 2'b01, 2'b00, 2'b01);
        fault_case("R8", 2'b00, 2'b00, 2'b10, 2'b00, 2'b10);
        fault_case("R9", 2'b01, 2'b00, 2'b00, 2'b01, 2'b10);
        fault_case("R9", 2'b10, 2'b00, 2'b00, 2'b10, 2'b01);

        // R10: stays halted, no drive, despite new valid words
        for (int k = 0; k < 5; k++) begin
            put(16'h4321 + k, 1'b1);
            step("R10");
            chk("R10", {31'd0, bus_oe}, 32'd0, "halted no drive");
        end
        chk("R10", {30'd0, fail}, 32'd1, "sticky flags");
        in_valid = 0;
        do_reset();
        chk("R10", {31'd0, halt}, 32'd0, "reset clears halt");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule